// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a word-addressed general-purpose I/O controller for `NUM_PINS` pins. The pins are split into banks of 32. Each bank has its own set of 32-bit registers: pin enable, output data, direction, sampled level, interrupt mask, pending status and edge select. Software programs these registers over a single-cycle register bus. The pads see an output value, an output enable and an input that is synchronised inside the block.

Every enabled, unmasked pin watches its synchronised input for one chosen edge, either rising or falling. When that edge occurs, the pin sets a sticky pending bit. The single interrupt line is the OR of every pending bit in every bank. Software clears pending bits by writing zeros. Writing back the inverse of the value it read clears exactly the bits it saw and leaves any bit that arrived later untouched.

The last bank may be partly populated. Its bits at or above `NUM_PINS` behave as permanently absent: they read zero, writes to them are dropped, and they never flag an interrupt.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The word address is `{kind[2:0], bank}`, with the bank index in the low `BANK_W` bits. The kind codes are: 0 enable, 1 output data, 2 direction, 3 sampled level (read-only), 4 interrupt mask, 5 pending status, 6 edge select, 7 unused. Pin p lives at bit p mod 32 of bank p div 32. Register writes take effect at the clock edge that samples `bus_we`. Reads are combinational from the address.
- R2: After reset, every valid pin reads as follows: enable 0, output data 0, direction 1, mask 1, status 0, edge select 0. In addition, `pin_oe` is 0 and `irq` is 0.
- R3: A pin drives only when its enable bit is 1 and its direction bit is 0. In that case `pin_oe` is 1 and `pin_out` equals its output-data bit. Otherwise both `pin_oe` and `pin_out` are 0.
- R4: The sampled-level register returns `pin_in` through a two-flop synchroniser. A change applied between edges is not visible after the first clock edge and is visible after the second.
- R5: With edge select 1, a 0→1 change of the synchronised input sets the pin's status bit. With edge select 0, a 1→0 change sets it. The opposite edge does nothing. The bit is set at the third clock edge after the input changes.
- R6: An edge sets a status bit only if the pin's enable bit is 1 and its mask bit is 0.
- R7: A status bit stays set until it is cleared. Writing to the status register clears every bit written as 0 and keeps every bit written as 1, so writing the inverse of the value read clears exactly those bits.
- R8: If an edge sets a status bit in the same cycle as a status write that clears it, the bit ends up set.
- R9: Bits at or above `NUM_PINS` in the last bank read 0 in every register, ignore writes, and never set status.
- R10: `irq` is 1 exactly when at least one status bit in any bank is 1.
- R11: Writes to the sampled-level register and to kind 7 change no register. Reads of kind 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address `{kind, bank}` |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pad inputs |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the collision in which a status clear and a new edge on the same pin land in the same clock cycle. The bench first makes a rising-edge pin pending, then lowers it, which leaves it pending because the falling edge is not selected. It then raises the pin again and places the clearing write exactly two cycles later, so the detected edge and the write share one clock edge. The bench also sweeps a single edge of each polarity across all 40 pins of the default configuration, with alternating edge selects. This covers the boundary bank and the absent upper bits.

// File: rtl/gpio_ctrl_pkg.sv
`timescale 1ns/1ps
package gpio_ctrl_pkg;

    localparam int WORD_W = 32;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        RK_ENABLE = 3'd0,
        RK_WDATA  = 3'd1,
        RK_DIR    = 3'd2,
        RK_LEVEL  = 3'd3,
        RK_MASK   = 3'd4,
        RK_STATUS = 3'd5,
        RK_EDGE   = 3'd6,
        RK_NONE   = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] enable;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] edge_sel;
    } bank_regs_t;

    function automatic int bank_count(int npins);
        return (npins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int bank_idx_w(int nbanks);
        return (nbanks > 1) ? $clog2(nbanks) : 1;
    endfunction

    function automatic logic [WORD_W-1:0] bank_valid(int npins, int bank);
        int left;
        left = npins - bank * WORD_W;
        if (left >= WORD_W) return '1;
        if (left <= 0) return '0;
        return (32'h1 << left) - 32'h1;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

    // R4: two-edge latency from pad to synchronised level
    p_sync_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter logic [WORD_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] lvl,
    output bank_regs_t        regs,
    output logic [WORD_W-1:0] pin_oe,
    output logic [WORD_W-1:0] pin_out
);
    bank_regs_t        regs_q;
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] rise, fall, hit, kept;
    logic [WORD_W-1:0] wmask;
    logic              wr_sts, wr_dir;

    assign wmask  = wr_data & VALID;
    assign wr_sts = wr_en && (wr_kind == RK_STATUS);
    assign wr_dir = wr_en && (wr_kind == RK_DIR);

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign hit  = regs_q.enable & ~regs_q.mask & VALID
                & ((regs_q.edge_sel & rise) | (~regs_q.edge_sel & fall));
    // zero written clears, one written keeps; a fresh edge always wins
    assign kept = wr_sts ? (regs_q.status & wr_data) : regs_q.status;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.enable   <= '0;
            regs_q.wdata    <= '0;
            regs_q.dir      <= VALID;
            regs_q.mask     <= VALID;
            regs_q.status   <= '0;
            regs_q.edge_sel <= '0;
            prev_q          <= '0;
        end else begin
            prev_q        <= lvl & VALID;
            regs_q.status <= (kept | hit) & VALID;
            if (wr_en) begin
                case (wr_kind)
                    RK_ENABLE: regs_q.enable   <= wmask;
                    RK_WDATA:  regs_q.wdata    <= wmask;
                    RK_DIR:    regs_q.dir      <= wmask;
                    RK_MASK:   regs_q.mask     <= wmask;
                    RK_EDGE:   regs_q.edge_sel <= wmask;
                    default:   ;
                endcase
            end
        end
    end

    assign regs    = regs_q;
    assign pin_oe  = regs_q.enable & ~regs_q.dir;
    assign pin_out = regs_q.wdata & pin_oe;

    // R6: a newly set status bit had its pin enabled and unmasked
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        ((regs_q.status & ~$past(regs_q.status))
          & ~$past(regs_q.enable & ~regs_q.mask)) == '0);

    // R7: status bits only fall through a status write
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (($past(regs_q.status) & ~regs_q.status) != '0) |-> $past(wr_sts));

    // R1: direction only moves on a direction write
    p_dir_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_dir) |-> $stable(regs_q.dir));

endmodule

// File: rtl/gpio_banked_ctrl.sv
`timescale 1ns/1ps
module gpio_banked_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 40,
    localparam int NUM_BANKS = bank_count(NUM_PINS),
    localparam int BANK_W    = bank_idx_w(NUM_BANKS),
    localparam int ADDR_W    = KIND_W + BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int PAD_W = NUM_BANKS * WORD_W;

    reg_kind_e          acc_kind;
    logic [BANK_W-1:0]  acc_bank;
    logic [NUM_PINS-1:0] lvl_sync;
    logic [PAD_W-1:0]   lvl_pad, oe_pad, out_pad;
    bank_regs_t         regs_arr [NUM_BANKS];
    logic [WORD_W-1:0]  lvl_bank [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend;

    assign acc_kind = reg_kind_e'(bus_addr[ADDR_W-1 -: KIND_W]);
    assign acc_bank = bus_addr[BANK_W-1:0];

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (lvl_sync)
    );

    assign lvl_pad = PAD_W'(lvl_sync);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.VALID(bank_valid(NUM_PINS, b))) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_we && (acc_bank == BANK_W'(b))),
            .wr_kind (acc_kind),
            .wr_data (bus_wdata),
            .lvl     (lvl_pad[b*WORD_W +: WORD_W]),
            .regs    (regs_arr[b]),
            .pin_oe  (oe_pad[b*WORD_W +: WORD_W]),
            .pin_out (out_pad[b*WORD_W +: WORD_W])
        );
        assign lvl_bank[b]  = lvl_pad[b*WORD_W +: WORD_W];
        assign bank_pend[b] = |regs_arr[b].status;
    end

    assign pin_oe  = oe_pad[NUM_PINS-1:0];
    assign pin_out = out_pad[NUM_PINS-1:0];
    assign irq     = |bank_pend;

    always_comb begin
        bus_rdata = '0;
        if (int'(acc_bank) < NUM_BANKS) begin
            case (acc_kind)
                RK_ENABLE: bus_rdata = regs_arr[acc_bank].enable;
                RK_WDATA:  bus_rdata = regs_arr[acc_bank].wdata;
                RK_DIR:    bus_rdata = regs_arr[acc_bank].dir;
                RK_LEVEL:  bus_rdata = lvl_bank[acc_bank];
                RK_MASK:   bus_rdata = regs_arr[acc_bank].mask;
                RK_STATUS: bus_rdata = regs_arr[acc_bank].status;
                RK_EDGE:   bus_rdata = regs_arr[acc_bank].edge_sel;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R2: no pad is driven in the first cycle after reset
    p_oe_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && !irq));

endmodule

// File: tb/tb_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_banked_ctrl;
    localparam int NP = 40;
    localparam logic [31:0] V1 = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_banked_ctrl #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [3:0] mk(int kind, int bank);
        return {3'(kind), 1'(bank)};
    endfunction

    function automatic logic [31:0] vmask(int bank);
        return (bank == 0) ? 32'hFFFF_FFFF : V1;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int kind, int bank, logic [31:0] d);
        @(negedge clk);
        bus_addr = mk(kind, bank);
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int kind, int bank, output logic [31:0] v);
        @(negedge clk);
        bus_addr = mk(kind, bank);
        #1 v = bus_rdata;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [NP-1:0] en40, dir40, wd40, exp_oe;
        waitn(4);
        rst = 1'b0;
        waitn(1);

        // R2 / R9: reset values per bank
        for (int b = 0; b < 2; b++) begin
            rd(0, b, v); check("R2 enable", v, 0);
            rd(1, b, v); check("R2 wdata", v, 0);
            rd(2, b, v); check("R2 dir", v, vmask(b));
            rd(4, b, v); check("R2 mask", v, vmask(b));
            rd(5, b, v); check("R2 status", v, 0);
            rd(6, b, v); check("R2 edge", v, 0);
        end
        check("R2 oe", pin_oe, 0);
        check("R2 irq", irq, 0);

        // R4: synchroniser latency and level sweep
        bus_addr = mk(3, 0);
        @(negedge clk);
        pin_in = 40'hC3_1234_ABCD;
        @(negedge clk); #1 check("R4 not yet", bus_rdata, 0);
        @(negedge clk); #1 check("R4 visible", bus_rdata, 32'h1234_ABCD);
        for (int k = 0; k < 4; k++) begin
            logic [NP-1:0] pat;
            pat = {8'(k * 37 + 5), 32'hF0E1_D2C3 ^ (32'h1111_1111 * k)};
            pin_in = pat;
            waitn(2);
            rd(3, 0, v); check("R4 level b0", v, pat[31:0]);
            rd(3, 1, v); check("R4 level b1", v, {24'h0, pat[39:32]});
        end

        // R11: writes to level and to kind 7 change nothing
        wr(3, 0, 32'h0); wr(7, 0, 32'hFFFF_FFFF); wr(7, 1, 32'hFFFF_FFFF);
        rd(3, 0, v); check("R11 level kept", v, pin_in[31:0]);
        rd(0, 0, v); check("R11 enable kept", v, 0);
        rd(2, 1, v); check("R11 dir kept", v, V1);
        rd(7, 0, v); check("R11 kind7 read", v, 0);
        pin_in = '0;
        waitn(3);

        // R9: absent bits in last bank drop writes
        wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, v); check("R9 enable b1", v, V1);
        wr(2, 1, 32'h0);         rd(2, 1, v); check("R9 dir clr b1", v, 0);
        wr(2, 1, 32'hFFFF_FFFF); rd(2, 1, v); check("R9 dir set b1", v, V1);
        wr(6, 1, 32'hFFFF_FF00); rd(6, 1, v); check("R9 edge b1", v, 0);

        // R3: output drive under several patterns
        for (int k = 0; k < 4; k++) begin
            en40  = {8'(8'hF0 ^ k), 32'hFFFF_0FFF ^ (32'h0101_0101 << k)};
            dir40 = {8'(8'h33 << k), 32'h0F0F_3C3C ^ (32'h7 << (4 * k))};
            wd40  = {8'(8'hA5 + k), 32'h5A5A_96C3 + 32'(k)};
            wr(0, 0, en40[31:0]);  wr(0, 1, {24'h0, en40[39:32]});
            wr(2, 0, dir40[31:0]); wr(2, 1, {24'h0, dir40[39:32]});
            wr(1, 0, wd40[31:0]);  wr(1, 1, {24'h0, wd40[39:32]});
            exp_oe = en40 & ~dir40;
            check("R3 oe", pin_oe, exp_oe);
            check("R3 out", pin_out, wd40 & exp_oe);
        end
        wr(2, 0, 32'hFFFF_FFFF); wr(2, 1, 32'hFFFF_FFFF);
        check("R3 released", pin_oe, 0);
        check("R3 out low", pin_out, 0);

        // R5: per-pin edge sweep, even pins rising, odd pins falling
        wr(0, 0, 32'hFFFF_FFFF); wr(0, 1, 32'hFFFF_FFFF);
        wr(4, 0, 32'h0); wr(4, 1, 32'h0);
        wr(6, 0, 32'h5555_5555); wr(6, 1, 32'h5555_5555);
        wr(5, 0, 32'h0); wr(5, 1, 32'h0);
        for (int p = 0; p < NP; p++) begin
            logic [31:0] bitv;
            bitv = 32'h1 << (p % 32);
            @(negedge clk); pin_in[p] = 1'b1;
            waitn(4);
            rd(5, p / 32, v);
            check("R5 rise", v, (p % 2 == 0) ? bitv : 32'h0);
            check("R10 irq rise", irq, (p % 2 == 0));
            rd(5, 1 - p / 32, v); check("R5 other bank", v, 0);
            wr(5, p / 32, 32'h0);
            @(negedge clk); pin_in[p] = 1'b0;
            waitn(4);
            rd(5, p / 32, v);
            check("R5 fall", v, (p % 2 == 1) ? bitv : 32'h0);
            wr(5, p / 32, 32'h0);
            check("R10 irq clear", irq, 0);
        end

        // R6: masked pin 3 and disabled pin 5 stay quiet
        wr(4, 0, 32'h8); wr(0, 0, ~32'h20);
        @(negedge clk); pin_in[3] = 1'b1; pin_in[5] = 1'b1;
        waitn(4);
        @(negedge clk); pin_in[3] = 1'b0; pin_in[5] = 1'b0;
        waitn(4);
        rd(5, 0, v); check("R6 gated", v, 0);
        check("R6 irq", irq, 0);
        wr(4, 0, 32'h0); wr(0, 0, 32'hFFFF_FFFF);

        // R7: sticky and clear-by-zero
        @(negedge clk); pin_in[2] = 1'b1; pin_in[1] = 1'b1;
        waitn(4);
        @(negedge clk); pin_in[1] = 1'b0;
        waitn(4);
        rd(5, 0, v); check("R7 pending", v, 32'h6);
        wr(5, 0, 32'hFFFF_FFFB);
        rd(5, 0, v); check("R7 partial clear", v, 32'h2);
        check("R7 irq held", irq, 1);
        rd(5, 0, v); wr(5, 0, ~v);
        rd(5, 0, v); check("R7 inverse clear", v, 0);

        // R8: edge and clearing write on the same clock edge
        @(negedge clk); pin_in[4] = 1'b1; pin_in[6] = 1'b1;
        waitn(4);
        rd(5, 0, v); check("R8 setup", v, 32'h50);
        @(negedge clk); pin_in[4] = 1'b0;
        waitn(4);
        @(negedge clk); pin_in[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = mk(5, 0); bus_we = 1'b1; bus_wdata = 32'h0;
        @(negedge clk); bus_we = 1'b0;
        rd(5, 0, v); check("R8 set wins", v, 32'h10);
        wr(5, 0, 32'h0);

        // R10: irq from bank 1 alone
        @(negedge clk); pin_in[33] = 1'b1;
        waitn(4);
        @(negedge clk); pin_in[33] = 1'b0;
        waitn(4);
        rd(5, 1, v); check("R10 b1 pending", v, 32'h2);
        check("R10 irq b1", irq, 1);
        wr(5, 1, 32'hFFFF_FFFD);
        check("R10 irq off", irq, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule